// File: doc/BRIEF.md
# Slot Access Controller with History Window

This block decides, slot by slot, whether one station on a slotted shared channel transmits. Every station always has a packet waiting. At the end of each slot the block stores its own action (sent or stayed silent) together with a one-bit channel outcome: high when exactly one station sent in that slot. The transmit decision for the next slot comes only from that stored history and an internal 16-bit pseudo-random generator.

A station that has succeeded recently stays quiet. Any other station contends with probability 1/(N − n), where n is the number of successful slots in its window. The window covers the N − 1 slots before the current one, so together with the current slot it spans N slots. N identical copies on one channel, each with its own seed, fall into a collision-free rotation with no central coordinator. In that rotation each station owns one slot in every N and the channel is never idle.

The integrator strobes the block once at the end of every slot, drives the channel outcome alongside the strobe, and reads the request for the following slot once that strobe edge has passed.

Top module: `slot_access_ctrl`

## Requirements
- R1: A synchronous reset empties the history window and loads the generator from `seed`; a zero seed is replaced by 16'hACE1. The same seed under the same outcome sequence gives the same `tx_req` sequence.
- R2: `tx_req` changes only in the cycle after a slot strobe, a reset, or a change of `num_users`; it holds steady for the whole slot.
- R3: On each strobe the pair (`tx_req`, `fb_ok`) of the slot just ending enters the window. The window holds the N − 1 most recent slots, so a recorded slot leaves it after exactly N − 1 further strobes.
- R4: While the window holds a slot in which this station sent and `fb_ok` was high, `tx_req` is low.
- R5: When the station is not silenced and the window holds n successful slots, it sends with probability 1/(N − n); with n = N − 1 it always sends.
- R6: `num_users` of 0 or 1 acts as N = 1 (send in every slot); a value above 16 acts as N = 16.
- R7: With no successful slot in the window, the long-run sending rate is close to 1/N (between 15 % and 35 % over 2000 slots for N = 4).
- R8: N copies with distinct seeds on one channel, where `fb_ok` is high exactly when one copy sends, reach a run of N consecutive successful slots within 3000 slots.
- R9: After that run, every slot has exactly one sender, and the sender of slot k is the sender of slot k − N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_strobe | input | 1 | One-cycle pulse at the end of each slot |
| fb_ok | input | 1 | Channel outcome of the ending slot, high when exactly one station sent |
| num_users | input | 5 | Number of stations N |
| seed | input | 16 | Generator seed, loaded during reset |
| tx_req | output | 1 | Send request for the current slot |

## Verification
The hardest state to reach from the ports is a window that holds an own success next to an exact number of other successes. Sending is random, so no fixed stimulus lands there. The bench holds the outcome low and strobes until the request happens to rise, then answers that slot with a success. It then feeds N − 1 successes from other stations, which makes the silenced span and the forced send that follows fully deterministic for N = 2, 4 and a clamped 20. Convergence is checked on a modelled channel with several seeds and sizes of N.

// File: rtl/slot_access_pkg.sv
package slot_access_pkg;

    // Upper bound on the number of stations sharing the channel
    localparam int MAX_USERS_DEF = 16;
    // Generator width and feedback mask (maximal-length Galois form)
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
    // Replacement for a zero seed, which would lock the generator
    localparam logic [LFSR_W-1:0] SEED_FALLBACK = 16'hACE1;

    // One recorded slot: own action and channel outcome
    typedef struct packed {
        logic sent;
        logic ok;
    } slot_rec_t;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        if (s[0]) begin
            return (s >> 1) ^ LFSR_TAPS;
        end
        return s >> 1;
    endfunction

    function automatic logic [LFSR_W-1:0] seed_fix(input logic [LFSR_W-1:0] s);
        return (s == '0) ? SEED_FALLBACK : s;
    endfunction

endpackage

// File: rtl/slot_history.sv
module slot_history
    import slot_access_pkg::*;
#(
    parameter int DEPTH = MAX_USERS_DEF - 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   shift_en,
    input  slot_rec_t              rec_in,
    output slot_rec_t [DEPTH-1:0]  hist
);

    slot_rec_t [DEPTH-1:0] hist_q;

    // Entry 0 is the most recent slot; older entries move up by one
    for (genvar j = 0; j < DEPTH; j++) begin : g_stage
        if (j == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q[j] <= '0;
                end else if (shift_en) begin
                    hist_q[j] <= rec_in;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q[j] <= '0;
                end else if (shift_en) begin
                    hist_q[j] <= hist_q[j-1];
                end
            end
        end
    end

    assign hist = hist_q;

endmodule

// File: rtl/window_eval.sv
module window_eval
    import slot_access_pkg::*;
#(
    parameter int DEPTH = MAX_USERS_DEF - 1,
    parameter int NW    = $clog2(MAX_USERS_DEF + 1)
) (
    input  slot_rec_t [DEPTH-1:0] hist,
    input  logic [NW-1:0]         win_len,
    output logic                  own_hit,
    output logic [NW-1:0]         succ_cnt
);

    logic [DEPTH-1:0] in_win;
    logic [DEPTH-1:0] ok_bits;
    logic [DEPTH-1:0] own_bits;

    // Only the newest win_len entries take part in the decision
    for (genvar j = 0; j < DEPTH; j++) begin : g_mask
        assign in_win[j]   = (NW'(j) < win_len);
        assign ok_bits[j]  = in_win[j] & hist[j].ok;
        assign own_bits[j] = in_win[j] & hist[j].ok & hist[j].sent;
    end

    always_comb begin
        succ_cnt = '0;
        for (int j = 0; j < DEPTH; j++) begin
            succ_cnt = succ_cnt + NW'(ok_bits[j]);
        end
    end

    assign own_hit = |own_bits;

endmodule

// File: rtl/lfsr_draw.sv
module lfsr_draw
    import slot_access_pkg::*;
#(
    parameter int NW = $clog2(MAX_USERS_DEF + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [LFSR_W-1:0] seed,
    input  logic [NW-1:0]     modulus,
    output logic              draw_zero,
    output logic [LFSR_W-1:0] state
);

    localparam int PAD = LFSR_W - NW;

    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] mod_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= seed_fix(seed);
        end else if (step) begin
            state_q <= lfsr_step(state_q);
        end
    end

    // Uniform-ish integer in [0, modulus-1]; a hit is a zero draw
    assign mod_ext   = {{PAD{1'b0}}, modulus};
    assign draw_zero = (modulus != '0) && ((state_q % mod_ext) == '0);
    assign state     = state_q;

endmodule

// File: rtl/slot_access_ctrl.sv
module slot_access_ctrl
    import slot_access_pkg::*;
#(
    parameter int MAX_USERS = MAX_USERS_DEF,
    parameter int NW        = $clog2(MAX_USERS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_strobe,
    input  logic              fb_ok,
    input  logic [NW-1:0]     num_users,
    input  logic [LFSR_W-1:0] seed,
    output logic              tx_req
);

    localparam int DEPTH = MAX_USERS - 1;

    logic [NW-1:0]          n_eff;
    logic [NW-1:0]          win_len;
    logic [NW-1:0]          room;
    logic [NW-1:0]          succ_cnt;
    logic                   own_hit;
    logic                   draw_zero;
    logic                   may_send;
    logic [LFSR_W-1:0]      lfsr_state;
    slot_rec_t              rec_now;
    slot_rec_t [DEPTH-1:0]  hist;

    // Clamp the station count into 1..MAX_USERS
    always_comb begin
        if (num_users == '0) begin
            n_eff = NW'(1);
        end else if (num_users > NW'(MAX_USERS)) begin
            n_eff = NW'(MAX_USERS);
        end else begin
            n_eff = num_users;
        end
    end

    assign win_len = n_eff - NW'(1);

    assign rec_now.sent = tx_req;
    assign rec_now.ok   = fb_ok;

    slot_history #(.DEPTH(DEPTH)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (slot_strobe),
        .rec_in   (rec_now),
        .hist     (hist)
    );

    window_eval #(.DEPTH(DEPTH), .NW(NW)) u_eval (
        .hist     (hist),
        .win_len  (win_len),
        .own_hit  (own_hit),
        .succ_cnt (succ_cnt)
    );

    // Contenders left in the window; guarded against a zero divisor
    assign may_send = !own_hit && (succ_cnt < n_eff);
    assign room     = may_send ? (n_eff - succ_cnt) : '0;

    lfsr_draw #(.NW(NW)) u_draw (
        .clk       (clk),
        .rst       (rst),
        .step      (slot_strobe),
        .seed      (seed),
        .modulus   (room),
        .draw_zero (draw_zero),
        .state     (lfsr_state)
    );

    assign tx_req = may_send && draw_zero;

endmodule

// File: rtl/slot_access_chk.sv
module slot_access_chk
    import slot_access_pkg::*;
#(
    parameter int NW = $clog2(MAX_USERS_DEF + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              slot_strobe,
    input logic              fb_ok,
    input logic [NW-1:0]     num_users,
    input logic [LFSR_W-1:0] seed,
    input logic              tx_req,
    input logic [LFSR_W-1:0] lfsr_state
);

    // R4: a slot won by this station silences the next one
    p_own_success_silences_r4: assert property (@(posedge clk) disable iff (rst)
        (slot_strobe && tx_req && fb_ok && num_users >= NW'(2))
        |=> (!tx_req || !$stable(num_users)));

    // R2: the request holds between strobes
    p_hold_between_slots_r2: assert property (@(posedge clk) disable iff (rst)
        (!slot_strobe) |=> (tx_req == $past(tx_req) || !$stable(num_users)));

    // R6: a single station always sends
    p_single_user_sends_r6: assert property (@(posedge clk) disable iff (rst)
        (num_users <= NW'(1)) |-> tx_req);

    // R1: the generator never locks at zero
    p_lfsr_live_r1: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != '0);

    // R1: the first state after reset is the (fixed-up) seed
    p_seed_load_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lfsr_state == (($past(seed) == '0) ? SEED_FALLBACK : $past(seed))));

endmodule

bind slot_access_ctrl slot_access_chk #(.NW(NW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .slot_strobe (slot_strobe),
    .fb_ok       (fb_ok),
    .num_users   (num_users),
    .seed        (seed),
    .tx_req      (tx_req),
    .lfsr_state  (lfsr_state)
);

// File: tb/slot_access_ctrl_tb.sv
module slot_access_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_DUT    = 4;
    localparam int NW         = 5;
    localparam int CONV_LIMIT = 3000;
    localparam int WATCHDOG   = 190000;

    // Convergence scenarios: {stations, seed base}
    localparam logic [20:0] CONV_TAB [4] = '{
        {5'd4, 16'h1D2B},
        {5'd3, 16'h7A11},
        {5'd2, 16'h0F0F},
        {5'd4, 16'hC35A}
    };

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic               rst      = 1'b1;
    logic               strobe   = 1'b0;
    logic               fb_force = 1'b0;
    logic               use_chan = 1'b0;
    logic [NW-1:0]      n_users  = 5'd4;
    logic [15:0]        seed_base = 16'h5A5A;
    logic [NUM_DUT-1:0] active   = '1;
    logic [NUM_DUT-1:0] tx;
    logic [15:0]        seeds [NUM_DUT];
    logic               chan_ok;
    logic               fb;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    assign chan_ok = ($countones(tx & active) == 1);
    assign fb      = use_chan ? chan_ok : fb_force;

    for (genvar i = 0; i < NUM_DUT; i++) begin : g_user
        assign seeds[i] = seed_base ^ 16'(i * 16'h3B17);
        slot_access_ctrl u_dut (
            .clk         (clk),
            .rst         (rst),
            .slot_strobe (strobe),
            .fb_ok       (fb),
            .num_users   (n_users),
            .seed        (seeds[i]),
            .tx_req      (tx[i])
        );
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_slot(input logic f);
        @(negedge clk);
        fb_force = f;
        strobe   = 1'b1;
        @(negedge clk);
        strobe   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Wait with failed slots until station 0 sends, then grant it the slot
    task automatic get_own_success(output bit got);
        got = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            if (tx[0]) begin
                do_slot(1'b1);
                got = 1'b1;
                break;
            end
            do_slot(1'b0);
        end
    endtask

    task automatic age_test(input logic [NW-1:0] nset, input int win);
        bit got;
        use_chan = 1'b0;
        n_users  = nset;
        do_reset();
        get_own_success(got);
        check(got, "R5", "station 0 eventually sends", int'(got), 1);
        for (int k = 0; k < win; k++) begin
            check(tx[0] == 1'b0, "R4", "silenced after own success", int'(tx[0]), 0);
            do_slot(1'b1);
        end
        // R3: own success has left the window; R5: n = N-1 forces a send
        check(tx[0] == 1'b1, "R3", "send once own success ages out", int'(tx[0]), 1);
    endtask

    task automatic record_seq(output logic [47:0] s);
        for (int k = 0; k < 48; k++) begin
            s[k] = tx[0];
            do_slot(1'b0);
        end
    endtask

    task automatic conv_run(input logic [NW-1:0] nset, input logic [15:0] base);
        int  run;
        bit  conv;
        int  pc;
        int  who;
        int  owner [16];
        use_chan  = 1'b1;
        n_users   = nset;
        seed_base = base;
        active    = NUM_DUT'((1 << nset) - 1);
        do_reset();
        run  = 0;
        conv = 1'b0;
        for (int s = 0; s < CONV_LIMIT && !conv; s++) begin
            pc = $countones(tx & active);
            run = (pc == 1) ? run + 1 : 0;
            do_slot(1'b0);
            if (run >= int'(nset)) conv = 1'b1;
        end
        check(conv, "R8", "reached N consecutive successes", int'(conv), 1);
        for (int k = 0; k < 4 * int'(nset); k++) begin
            pc  = $countones(tx & active);
            who = -1;
            for (int b = 0; b < NUM_DUT; b++) begin
                if (tx[b] && active[b]) who = b;
            end
            check(pc == 1, "R9", "exactly one sender per slot", pc, 1);
            if (k >= int'(nset)) begin
                check(who == owner[k % int'(nset)], "R9", "cyclic slot owner", who,
                      owner[k % int'(nset)]);
            end
            owner[k % int'(nset)] = who;
            do_slot(1'b0);
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [47:0] seq_a;
        logic [47:0] seq_b;
        bit          got;
        int          hits;
        logic        t0;

        // Table of convergence scenarios on a modelled channel (R8, R9)
        for (int v = 0; v < 4; v++) begin
            conv_run(CONV_TAB[v][20:16], CONV_TAB[v][15:0]);
        end

        // R6: num_users of 0 and 1 send in every slot, even after success
        use_chan = 1'b0;
        active   = '1;
        seed_base = 16'h2468;
        n_users  = 5'd0;
        do_reset();
        check(tx[0] == 1'b1, "R6", "N=0 after reset", int'(tx[0]), 1);
        for (int k = 0; k < 4; k++) begin
            do_slot(1'b1);
            check(tx[0] == 1'b1, "R6", "N=0 after success", int'(tx[0]), 1);
        end
        n_users = 5'd1;
        do_reset();
        do_slot(1'b1);
        check(tx[0] == 1'b1, "R6", "N=1 after success", int'(tx[0]), 1);

        // R3, R4, R5: silenced span and forced send for several N
        age_test(5'd4, 3);
        age_test(5'd2, 1);
        // R6: 20 is clamped to 16, window of 15 slots
        age_test(5'd20, 15);

        // R1: reset clears history and reloads the seed
        n_users   = 5'd4;
        seed_base = 16'h5A5A;
        do_reset();
        record_seq(seq_a);
        get_own_success(got);
        do_slot(1'b1);
        do_slot(1'b1);
        do_reset();
        record_seq(seq_b);
        check(seq_a == seq_b, "R1", "sequence repeats after reset",
              int'(seq_b[31:0]), int'(seq_a[31:0]));

        // R1: zero seed behaves as 16'hACE1
        seed_base = 16'h0000;
        do_reset();
        record_seq(seq_a);
        seed_base = 16'hACE1;
        do_reset();
        record_seq(seq_b);
        check(seq_a == seq_b, "R1", "zero seed fallback",
              int'(seq_a[31:0]), int'(seq_b[31:0]));

        // R7 rate with failed slots only; R2 request steady mid-slot
        seed_base = 16'h9C4D;
        n_users   = 5'd4;
        do_reset();
        hits = 0;
        for (int k = 0; k < 2000; k++) begin
            t0 = tx[0];
            repeat (2) @(negedge clk);
            check(tx[0] == t0, "R2", "request stable inside slot", int'(tx[0]), int'(t0));
            if (t0) hits++;
            do_slot(1'b0);
        end
        check(hits >= 300 && hits <= 700, "R7", "send count out of 2000 slots", hits, 500);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule